// File: doc/BRIEF.md
# Byte-Lane Strobe Generator for Narrow and Unaligned Bursts

This block works out, for each beat of a memory-mapped burst, which byte lanes of the data bus carry that beat. A write master uses the resulting mask as its write strobe. A read master uses it to pick the valid bytes out of a wide read word. Upstream logic supplies the beat address, for example from a burst address sequencer. The block also receives the burst's start address, the transfer size code, the burst kind and a flag that marks the first beat. It does not generate addresses and it does not move data.

When a beat is narrower than the bus, the low address bits and the size select an aligned group of lanes. Incrementing and wrapping bursts move across the lanes beat by beat. A fixed burst always uses the lanes given by its start address. On the first beat of an unaligned transfer, lanes below the start byte inside the aligned group are cleared. The result is combinational. A parameter can add one register stage.

Top module: `lane_strobe_gen`

## Requirements
- R1: `laneMask` has one bit per byte of the data bus (DATA_W/8 bits). Bit n qualifies data bits [8n+7:8n].
- R2: For incrementing (burstKind 2'b01) and wrapping (2'b10) bursts, the active lanes form the group of 2^size lanes that holds lane (beatAddr mod DATA_W/8), aligned down to a multiple of 2^size. Example: a 64-bit bus with 8-bit beats from address 0 gives lanes 0,1,2,3,4,5,6,7, then lane 0 again at address 8.
- R3: For fixed bursts (burstKind 2'b00), lanes are chosen from `startAddr` and `beatAddr` is ignored. Every beat after the first asserts the same lanes.
- R4: When `firstBeat` is high, lanes whose index is below the start byte offset are cleared. The offset is taken from `beatAddr` for incrementing and wrapping bursts and from `startAddr` for fixed bursts. Example: a 32-bit beat at 0x1002 on a 64-bit bus gives mask 8'h0C.
- R5: `xferSize` code k means 2^k bytes per beat (0 to 7 gives 1 to 128 bytes). A code wider than the bus is treated as the full bus.
- R6: burstKind 2'b11 is reserved and produces an all-zero mask.
- R7: While `beatValid` is low, `laneMask` is zero.
- R8: With REG_OUT=0 the outputs follow the inputs in the same cycle. With REG_OUT=1, `laneMask` and `maskValid` appear one clock later, and reset (active-low `rstN`) clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output stage |
| beatValid | input | 1 | The current beat inputs are meaningful |
| beatAddr | input | ADDR_W | Byte address of the current beat |
| startAddr | input | ADDR_W | Byte address of the first beat of the burst |
| xferSize | input | 3 | Log2 of the bytes per beat |
| burstKind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| firstBeat | input | 1 | The current beat is the first of its burst |
| laneMask | output | DATA_W/8 | Active byte lanes of the beat |
| maskValid | output | 1 | `laneMask` belongs to a valid beat |

## Verification
The lane-count assertion relies on upstream logic placing every beat after the first on an address aligned to its size. The fixed-burst stability assertion relies on `startAddr` and the size staying constant across one burst. The stimulus uses only aligned addresses for beats after the first, and it keeps the start address and size fixed within each burst. Unaligned offsets appear only on first beats. Reserved and idle beats are also driven, to check that they produce zero lanes.

// File: rtl/lane_strobe_pkg.sv
package lane_strobe_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [2:0] sizeLog;   // clamped log2 of beat bytes
    logic       useStart;  // take lane offset from start address
    logic       trimLow;   // clear lanes below the offset
    logic       kill;      // force an all-zero mask
  } laneCtl_t;

endpackage

// File: rtl/lane_strobe_ctl.sv
module lane_strobe_ctl
  import lane_strobe_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic       beatValid,
  input  logic [2:0] xferSize,
  input  logic [1:0] burstKind,
  input  logic       firstBeat,
  output laneCtl_t   ctl
);

  burst_e kind;

  always_comb begin
    kind         = burst_e'(burstKind);
    ctl.kill     = !beatValid || (kind == BURST_RSVD);
    ctl.useStart = (kind == BURST_FIXED);
    ctl.trimLow  = firstBeat;
    // A size wider than the bus collapses to the full bus
    if (xferSize > 3'(OFF_W)) ctl.sizeLog = 3'(OFF_W);
    else                      ctl.sizeLog = xferSize;
  end

endmodule

// File: rtl/lane_strobe_dp.sv
module lane_strobe_dp
  import lane_strobe_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] beatAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  laneCtl_t          ctl,
  output logic [LANES-1:0]  laneMask
);

  logic [ADDR_W-1:0] selAddr;
  logic [OFF_W-1:0]  offset;

  assign selAddr = ctl.useStart ? startAddr : beatAddr;
  assign offset  = selAddr[OFF_W-1:0];

  // One lane decision per byte of the bus
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] laneIdx;
    logic             sameGroup;
    logic             keepLane;
    assign laneIdx     = OFF_W'(i);
    assign sameGroup   = ((laneIdx ^ offset) >> ctl.sizeLog) == '0;
    assign keepLane    = !ctl.trimLow || (laneIdx >= offset);
    assign laneMask[i] = !ctl.kill && sameGroup && keepLane;
  end

  // Checking aid: lanes strictly below the start offset
  logic [LANES-1:0] belowStart;
  for (genvar j = 0; j < LANES; j++) begin : g_below
    assign belowStart[j] = (j < int'(offset));
  end

  // R6
  kill_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.kill |-> laneMask == '0);

  // R2
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.kill && !ctl.trimLow) |-> $countones(laneMask) == (1 << ctl.sizeLog));

  // R4
  first_trim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.kill && ctl.trimLow) |-> (laneMask & belowStart) == '0);

endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
  import lane_strobe_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 16,
  parameter bit REG_OUT = 1'b1,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              beatValid,
  input  logic [ADDR_W-1:0] beatAddr,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        xferSize,
  input  logic [1:0]        burstKind,
  input  logic              firstBeat,
  output logic [LANES-1:0]  laneMask,
  output logic              maskValid
);

  laneCtl_t         ctl;
  logic [LANES-1:0] combMask;

  lane_strobe_ctl #(.DATA_W(DATA_W)) i_ctl (
    .beatValid (beatValid),
    .xferSize  (xferSize),
    .burstKind (burstKind),
    .firstBeat (firstBeat),
    .ctl       (ctl)
  );

  lane_strobe_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .beatAddr  (beatAddr),
    .startAddr (startAddr),
    .ctl       (ctl),
    .laneMask  (combMask)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneMask  <= '0;
        maskValid <= 1'b0;
      end else begin
        laneMask  <= combMask;
        maskValid <= beatValid;
      end
    end

    // R8
    reg_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> (laneMask == $past(combMask)) && (maskValid == $past(beatValid)));
  end else begin : g_comb
    assign laneMask  = combMask;
    assign maskValid = beatValid;
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskValid |-> laneMask == '0);

  // R3
  fixed_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && burstKind == BURST_FIXED && !firstBeat &&
     $past(beatValid && burstKind == BURST_FIXED && !firstBeat) &&
     $stable(startAddr) && $stable(xferSize)) |-> $stable(combMask));

endmodule

// File: tb/test_lane_strobe_gen.sv
`timescale 1ns/1ps
module test_lane_strobe_gen;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 16;
  localparam int LANES  = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              beatValid = 1'b0;
  logic [ADDR_W-1:0] beatAddr = '0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [2:0]        xferSize = '0;
  logic [1:0]        burstKind = '0;
  logic              firstBeat = 1'b0;
  logic [LANES-1:0]  laneMask;
  logic              maskValid;

  int nChecks = 0;
  int nFails  = 0;
  logic [LANES:0] expQ[$];
  string          tagQ[$];

  always #2.5 clk = ~clk;

  lane_strobe_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OUT(1'b1)) i_lane_strobe_gen (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatAddr(beatAddr),
    .startAddr(startAddr), .xferSize(xferSize), .burstKind(burstKind),
    .firstBeat(firstBeat), .laneMask(laneMask), .maskValid(maskValid)
  );

  // Expected lanes from the requirement text
  function automatic logic [LANES-1:0] model(bit v, int addr, int start, int size, int kind, bit first);
    int bytes, a, off, base;
    logic [LANES-1:0] m;
    if (!v || kind == 3) return '0;
    if (size > 3) size = 3;
    bytes = 1 << size;
    a     = (kind == 0) ? start : addr;
    off   = a % LANES;
    base  = (off / bytes) * bytes;
    m     = LANES'(((1 << bytes) - 1) << base);
    if (first) m &= LANES'(~((1 << off) - 1));
    return m;
  endfunction

  task automatic check(string req, logic [LANES-1:0] gotM, logic gotV, logic [LANES-1:0] expM, logic expV);
    nChecks++;
    if (gotM !== expM || gotV !== expV) begin
      nFails++;
      $display("FAIL %s: mask=%h valid=%b expected mask=%h valid=%b", req, gotM, gotV, expM, expV);
    end
  endtask

  task automatic drive(string req, bit v, int addr, int start, int size, int kind, bit first);
    @(negedge clk);
    beatValid = v;
    beatAddr  = ADDR_W'(addr);
    startAddr = ADDR_W'(start);
    xferSize  = 3'(size);
    burstKind = 2'(kind);
    firstBeat = first;
    expQ.push_back({v, model(v, addr, start, size, kind, first)});
    tagQ.push_back(req);
  endtask

  // Monitor: one registered result per driven beat
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [LANES:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, laneMask, maskValid, e[LANES-1:0], e[LANES]);
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: mask=%h valid=%b expected mask=done valid=done", laneMask, maskValid);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R8: inputs active during reset, outputs held at zero
    beatValid = 1'b1; burstKind = 2'b01; xferSize = 3'd3;
    repeat (3) @(posedge clk);
    #1 check("R8 reset", laneMask, maskValid, '0, 1'b0);
    @(negedge clk);
    beatValid = 1'b0;
    rstN = 1'b1;

    // R2/R1: byte beats walking lanes 0..7 then back to lane 0
    for (int k = 0; k <= 8; k++) drive("R2 incr byte walk", 1, k, 0, 0, 1, k == 0);
    // R2: word beats from 4 alternate upper and lower halves
    drive("R2 word start 4", 1, 4, 4, 2, 1, 1);
    drive("R2 word next",    1, 8, 4, 2, 1, 0);
    drive("R2 word next",    1, 12, 4, 2, 1, 0);
    // R4: unaligned word start 0x1002 -> 8'h0C, then aligned 8'hF0
    drive("R4 unaligned word", 1, 'h1002, 'h1002, 2, 1, 1);
    drive("R4 following beat", 1, 'h1004, 'h1002, 2, 1, 0);
    // R4: unaligned doubleword at 0x1003 -> 8'hF8, then full bus
    drive("R4 unaligned dword", 1, 'h1003, 'h1003, 3, 1, 1);
    drive("R1 full bus beat",   1, 'h1008, 'h1003, 3, 1, 0);
    // R2: wrapping halfword burst 0xC, 0xE, 0x8, 0xA
    drive("R2 wrap", 1, 'hC, 'hC, 1, 2, 1);
    drive("R2 wrap", 1, 'hE, 'hC, 1, 2, 0);
    drive("R2 wrap", 1, 'h8, 'hC, 1, 2, 0);
    drive("R2 wrap", 1, 'hA, 'hC, 1, 2, 0);
    // R3: fixed burst ignores beatAddr
    drive("R3 fixed first", 1, 'h6, 'h6, 1, 0, 1);
    drive("R3 fixed addr ignored", 1, 'h20, 'h6, 1, 0, 0);
    drive("R3 fixed addr ignored", 1, 'h31, 'h6, 1, 0, 0);
    // R3/R4: unaligned fixed start 5 -> 8'h20 first, then 8'h30
    drive("R4 fixed unaligned first", 1, 'h40, 5, 1, 0, 1);
    drive("R3 fixed repeat", 1, 'h42, 5, 1, 0, 0);
    drive("R3 fixed repeat", 1, 'h44, 5, 1, 0, 0);
    // R5: size wider than bus clamps to full bus
    drive("R5 size clamp", 1, 'h10, 'h10, 5, 1, 0);
    drive("R5 size 7 clamp", 1, 'h3, 'h3, 7, 1, 1);
    // R6: reserved burst gives zero lanes
    drive("R6 reserved", 1, 'h4, 'h4, 2, 3, 1);
    // R7: idle beat gives zero lanes
    drive("R7 idle", 0, 'h4, 'h4, 2, 1, 0);
    drive("R2 after idle", 1, 'h6, 'h0, 1, 1, 0);

    @(negedge clk);
    beatValid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule